// File: doc/BRIEF.md
# Global Configuration Command Decoder

This block takes a single 32-bit configuration word, qualified by a one-cycle write strobe, and routes it to one of six chip-wide functions. The function is chosen by the position of the word's lowest set bit. The payload for that function sits in the bits above the selector.

- Bit 0 set: the word seeds the random-number generator.
- Lowest set bit 1: the word sets up the PLL.
- Lowest set bit 5: the word picks the clock source.
- Lowest set bit 6: the word programs one of four input filters.
- Lowest set bit 7: the word sets or clears write protection of the top 16 KB of RAM.
- Lowest set bit 8: the word requests a chip reset.

The block only holds the control registers and produces the strobes. The oscillators, the PLL itself and the generator datapath sit elsewhere.

The write-protect state also guards a RAM write port. While protection is on, a write request whose byte address falls in the protected top region is refused. A violation flag is raised in the same cycle.

Words that are malformed are discarded and reported with a one-cycle error flag. A word is malformed when it is all zero, when its lowest set bit selects no function, or when it has ones in bits its format requires to be zero.

Top module: `gcfg_dispatch`

## Requirements
- R1: A word with bit 0 = 1 drives `seed_value` with bits [31:1] and pulses `seed_load` high for exactly one cycle, both in the cycle after the strobe.
- R2: A word whose lowest set bit is 1 and whose bits [31:24] are zero loads the PLL fields: mode = [3:2], multiplier = [13:4], divider = [19:14], post-divider = [23:20]. It also sets `pll_ready`. The PLL fields change on no other command.
- R3: A clock-select word has lowest set bit 5 and bits [31:8] zero. It loads `clk_src` from bits [7:6]. The encoding is 00 fast internal, 01 slow internal (about 20 kHz), 10 crystal, 11 PLL. A request for 11 while `pll_ready` is low leaves `clk_src` unchanged.
- R4: `power_down` is high exactly while `clk_src` = 01. `ext_clk_in` is high exactly while the PLL mode field = 01, the mode in which XO drives the inverse of XI with no load capacitance.
- R5: A filter word has lowest set bit 6 and bits [31:16] zero. It writes filter index [15:14] with length [13:12] and tap [11:7]. In `flt_cfg`, filter k occupies bits [7k+6:7k], holding the tap in the low 5 bits and the length in the upper 2 bits.
- R6: A protect word has lowest set bit 7 and bits [31:9] zero. It sets `wp_on` to bit 8.
- R7: A reset word is exactly 0x100. It drives `sys_reset_pulse` high for RST_CYCLES consecutive cycles, starting the cycle after the strobe.
- R8: Some words are rejected: a zero word, a word whose lowest set bit is 2, 3, 4 or 9 and above, and a word with ones in required-zero bits. A rejected word changes no register and raises `cmd_error` for one cycle, in the cycle after the strobe.
- R9: While `wp_on` is high, a write request with address >= RAM_BYTES-PROT_BYTES gets `ram_wr_grant` low and `wp_violation` high in the same cycle. Otherwise `ram_wr_grant` follows `ram_wr_req` and `wp_violation` is low.
- R10: After reset, the block comes up in a fixed state:
  - `clk_src` = 00.
  - `pll_ready` low and every PLL field zero.
  - All filters zero.
  - `wp_on` low.
  - `seed_load`, `cmd_error` and `sys_reset_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Write strobe for `cmd_word` |
| cmd_word | input | 32 | Configuration word |
| ram_wr_req | input | 1 | RAM write request to be gated |
| ram_wr_addr | input | AW | RAM byte address of the request |
| seed_load | output | 1 | One-cycle seed load strobe |
| seed_value | output | 31 | Seed payload |
| pll_mode | output | 2 | Held PLL mode field |
| pll_mult | output | 10 | Held PLL multiplier |
| pll_div | output | 6 | Held PLL divider |
| pll_post | output | 4 | Held PLL post-divider |
| pll_ready | output | 1 | PLL has been configured since reset |
| ext_clk_in | output | 1 | External clock-input mode selected |
| clk_src | output | 2 | Selected clock source |
| power_down | output | 1 | Slow internal oscillator selected |
| flt_cfg | output | 28 | Four packed filter configurations |
| wp_on | output | 1 | Top-region write protection active |
| ram_wr_grant | output | 1 | Write request allowed through |
| wp_violation | output | 1 | Write request refused by protection |
| cmd_error | output | 1 | One-cycle rejected-command flag |
| sys_reset_pulse | output | 1 | Chip reset request pulse |

## Verification
The situation hardest to reach from the ports is a clock-select request for the PLL source.

The bench covers both halves of that rule. It first sends the PLL request before any PLL word has been accepted, and confirms the source holds. It then sends a PLL word with stray ones in its must-be-zero byte, which must be rejected, and repeats the request to confirm the source still holds. Only after a clean PLL word is the same request expected to succeed.

Words whose lowest set bit falls in the unused positions, and words that select a valid function but carry a stray upper bit, are mixed into the same sequence. This shows that rejection leaves every held register untouched.

// File: rtl/gcfg_pkg.sv
// Package: shared command kinds and field geometry for the configuration decoder.
// Assumes a 32-bit command word with the selector held in the low bits.
package gcfg_pkg;
    localparam int WORD_W   = 32;
    localparam int SEED_W   = WORD_W - 1;
    localparam int MODE_W   = 2;
    localparam int MULT_W   = 10;
    localparam int DIV_W    = 6;
    localparam int POST_W   = 4;
    localparam int SRC_W    = 2;
    localparam int TAP_W    = 5;
    localparam int LEN_W    = 2;
    localparam int FIDX_W   = 2;
    localparam int NFILT    = 1 << FIDX_W;
    localparam int FCFG_W   = TAP_W + LEN_W;

    localparam logic [SRC_W-1:0] SRC_FAST = 2'b00;
    localparam logic [SRC_W-1:0] SRC_SLOW = 2'b01;
    localparam logic [SRC_W-1:0] SRC_PLL  = 2'b11;

    typedef enum logic [2:0] {
        CK_SEED,
        CK_PLL,
        CK_CLK,
        CK_FLT,
        CK_WP,
        CK_RST,
        CK_BAD
    } cmd_kind_t;
endpackage

// File: rtl/gcfg_classify.sv
// Module: gcfg_classify
// Combinationally classifies a command word by its lowest set bit and
// checks that every bit the selected format requires to be zero is zero.
// Assumes nothing about cmd_valid; the caller qualifies the result.
module gcfg_classify
    import gcfg_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_kind_t         kind
);
    logic [5:0] low_idx;
    logic       any_set;

    // Find the position of the lowest set bit.
    always_comb begin
        low_idx = 6'd0;
        any_set = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (word[i]) begin
                low_idx = 6'(i);
                any_set = 1'b1;
            end
        end
    end

    // Map the selector position and zero-field rules to a command kind.
    always_comb begin
        kind = CK_BAD;
        if (any_set) begin
            case (low_idx)
                6'd0: kind = CK_SEED;
                6'd1: kind = (word[31:24] == '0) ? CK_PLL : CK_BAD;
                6'd5: kind = (word[31:8]  == '0) ? CK_CLK : CK_BAD;
                6'd6: kind = (word[31:16] == '0) ? CK_FLT : CK_BAD;
                6'd7: kind = (word[31:9]  == '0) ? CK_WP  : CK_BAD;
                6'd8: kind = (word[31:9]  == '0) ? CK_RST : CK_BAD;
                default: kind = CK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/gcfg_regs.sv
// Module: gcfg_regs
// Holds the seed strobe, PLL fields, clock source, filter set, protect flag
// and error flag, updating each only on its own accepted command.
// Assumes kind is the classification of the word presented with valid.
module gcfg_regs
    import gcfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic [WORD_W-1:0]       word,
    input  cmd_kind_t               kind,
    output logic                    seed_load,
    output logic [SEED_W-1:0]       seed_value,
    output logic [MODE_W-1:0]       pll_mode,
    output logic [MULT_W-1:0]       pll_mult,
    output logic [DIV_W-1:0]        pll_div,
    output logic [POST_W-1:0]       pll_post,
    output logic                    pll_ready,
    output logic [SRC_W-1:0]        clk_src,
    output logic [NFILT*FCFG_W-1:0] flt_cfg,
    output logic                    wp_on,
    output logic                    cmd_error
);
    logic take;
    assign take = valid;

    // Seed strobe and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_load  <= 1'b0;
            seed_value <= '0;
        end else begin
            seed_load <= take && (kind == CK_SEED);
            if (take && kind == CK_SEED)
                seed_value <= word[WORD_W-1:1];
        end
    end

    // PLL field registers and configured flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_mode  <= '0;
            pll_mult  <= '0;
            pll_div   <= '0;
            pll_post  <= '0;
            pll_ready <= 1'b0;
        end else if (take && kind == CK_PLL) begin
            pll_mode  <= word[3:2];
            pll_mult  <= word[13:4];
            pll_div   <= word[19:14];
            pll_post  <= word[23:20];
            pll_ready <= 1'b1;
        end
    end

    // Clock source with the PLL-readiness guard.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_src <= SRC_FAST;
        else if (take && kind == CK_CLK)
            if (word[7:6] != SRC_PLL || pll_ready)
                clk_src <= word[7:6];
    end

    // One register per filter, selected by the index field.
    for (genvar k = 0; k < NFILT; k++) begin : g_flt
        always_ff @(posedge clk) begin
            if (!rst_n)
                flt_cfg[k*FCFG_W +: FCFG_W] <= '0;
            else if (take && kind == CK_FLT && word[15:14] == FIDX_W'(k))
                flt_cfg[k*FCFG_W +: FCFG_W] <= {word[13:12], word[11:7]};
        end
    end

    // Write-protect flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_on <= 1'b0;
        else if (take && kind == CK_WP)
            wp_on <= word[8];
    end

    // Rejected-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_error <= 1'b0;
        else
            cmd_error <= take && (kind == CK_BAD);
    end

    assert_seed_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == CK_SEED) |=> seed_load);
    assert_pll_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && kind == CK_PLL) |=> ($stable(pll_mult) && $stable(pll_div) && $stable(pll_post)));
    assert_no_pll_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_ready |=> clk_src != SRC_PLL);
    assert_filter_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && kind == CK_FLT) |=> $stable(flt_cfg));
    assert_error_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> ($stable(wp_on) && $stable(clk_src) && $stable(pll_ready)));
endmodule

// File: rtl/gcfg_reset_timer.sv
// Module: gcfg_reset_timer
// Stretches an accepted reset command into a pulse of a fixed length.
// Assumes start is a single-cycle request; a new request restarts the count.
module gcfg_reset_timer #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    logic [CW-1:0] remain;

    // Load on request, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CW'(RST_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);

    assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pulse);
endmodule

// File: rtl/gcfg_wp_gate.sv
// Module: gcfg_wp_gate
// Refuses RAM writes into the protected top region while protection is on.
// Assumes byte addresses below RAM_BYTES and a purely combinational path.
module gcfg_wp_gate #(
    parameter int RAM_BYTES  = 524288,
    parameter int PROT_BYTES = 16384,
    parameter int AW         = $clog2(RAM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_on,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic          grant,
    output logic          violation
);
    localparam logic [AW-1:0] PROT_BASE = AW'(RAM_BYTES - PROT_BYTES);
    logic in_top;

    // Decide whether the request lands in the guarded region.
    always_comb begin
        in_top    = (addr >= PROT_BASE);
        violation = req && wp_on && in_top;
        grant     = req && !violation;
    end

    assert_gate_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (!grant && wp_on));
endmodule

// File: rtl/gcfg_dispatch.sv
// Module: gcfg_dispatch (top)
// Decodes a configuration word by lowest set bit and drives the global
// control registers, reset pulse and RAM write-protect gate.
// Assumes cmd_word is sampled only on cycles where cmd_valid is high.
module gcfg_dispatch
    import gcfg_pkg::*;
#(
    parameter int RAM_BYTES  = 524288,
    parameter int PROT_BYTES = 16384,
    parameter int RST_CYCLES = 4,
    parameter int AW         = $clog2(RAM_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [31:0]             cmd_word,
    input  logic                    ram_wr_req,
    input  logic [AW-1:0]           ram_wr_addr,
    output logic                    seed_load,
    output logic [30:0]             seed_value,
    output logic [1:0]              pll_mode,
    output logic [9:0]              pll_mult,
    output logic [5:0]              pll_div,
    output logic [3:0]              pll_post,
    output logic                    pll_ready,
    output logic                    ext_clk_in,
    output logic [1:0]              clk_src,
    output logic                    power_down,
    output logic [27:0]             flt_cfg,
    output logic                    wp_on,
    output logic                    ram_wr_grant,
    output logic                    wp_violation,
    output logic                    cmd_error,
    output logic                    sys_reset_pulse
);
    cmd_kind_t kind;

    gcfg_classify u_cls (
        .word (cmd_word),
        .kind (kind)
    );

    gcfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (cmd_valid),
        .word       (cmd_word),
        .kind       (kind),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .pll_mode   (pll_mode),
        .pll_mult   (pll_mult),
        .pll_div    (pll_div),
        .pll_post   (pll_post),
        .pll_ready  (pll_ready),
        .clk_src    (clk_src),
        .flt_cfg    (flt_cfg),
        .wp_on      (wp_on),
        .cmd_error  (cmd_error)
    );

    gcfg_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_valid && kind == CK_RST),
        .pulse (sys_reset_pulse)
    );

    gcfg_wp_gate #(.RAM_BYTES(RAM_BYTES), .PROT_BYTES(PROT_BYTES), .AW(AW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_on     (wp_on),
        .req       (ram_wr_req),
        .addr      (ram_wr_addr),
        .grant     (ram_wr_grant),
        .violation (wp_violation)
    );

    // Mode indicators derived from held registers.
    always_comb begin
        power_down = (clk_src == SRC_SLOW);
        ext_clk_in = (pll_mode == 2'b01);
    end

    assert_pd_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_down) |-> $past(cmd_valid));
    assert_error_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> $past(cmd_valid));
endmodule

// File: tb/gcfg_dispatch_test.sv
// Bench for gcfg_dispatch: a vector table, then directed corner cases.
module gcfg_dispatch_test;
    localparam int RAM_BYTES  = 524288;
    localparam int PROT_BYTES = 16384;
    localparam int RST_CYCLES = 4;
    localparam int AW         = $clog2(RAM_BYTES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [31:0]   cmd_word = '0;
    logic          ram_wr_req = 1'b0;
    logic [AW-1:0] ram_wr_addr = '0;
    logic          seed_load;
    logic [30:0]   seed_value;
    logic [1:0]    pll_mode;
    logic [9:0]    pll_mult;
    logic [5:0]    pll_div;
    logic [3:0]    pll_post;
    logic          pll_ready, ext_clk_in, power_down;
    logic [1:0]    clk_src;
    logic [27:0]   flt_cfg;
    logic          wp_on, ram_wr_grant, wp_violation, cmd_error, sys_reset_pulse;

    int runs = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gcfg_dispatch #(.RAM_BYTES(RAM_BYTES), .PROT_BYTES(PROT_BYTES),
                    .RST_CYCLES(RST_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ram_wr_req(ram_wr_req), .ram_wr_addr(ram_wr_addr),
        .seed_load(seed_load), .seed_value(seed_value),
        .pll_mode(pll_mode), .pll_mult(pll_mult), .pll_div(pll_div),
        .pll_post(pll_post), .pll_ready(pll_ready), .ext_clk_in(ext_clk_in),
        .clk_src(clk_src), .power_down(power_down), .flt_cfg(flt_cfg),
        .wp_on(wp_on), .ram_wr_grant(ram_wr_grant), .wp_violation(wp_violation),
        .cmd_error(cmd_error), .sys_reset_pulse(sys_reset_pulse)
    );

    // {word, expected error, expected clk_src, expected wp_on}
    localparam logic [35:0] VEC [13] = '{
        {32'h000000E0, 1'b0, 2'd0, 1'b0},
        {32'h00000060, 1'b0, 2'd1, 1'b0},
        {32'h00000000, 1'b1, 2'd1, 1'b0},
        {32'h00000180, 1'b0, 2'd1, 1'b1},
        {32'h00000004, 1'b1, 2'd1, 1'b1},
        {32'h000000A0, 1'b0, 2'd2, 1'b1},
        {32'h00000120, 1'b1, 2'd2, 1'b1},
        {32'h010000CA, 1'b1, 2'd2, 1'b1},
        {32'h000000E0, 1'b0, 2'd2, 1'b1},
        {32'h0000000E, 1'b0, 2'd2, 1'b1},
        {32'h000000E0, 1'b0, 2'd3, 1'b1},
        {32'h00000080, 1'b0, 2'd3, 1'b0},
        {32'h00000200, 1'b1, 2'd3, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one word for one cycle; return at the negedge after the capturing edge.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic check_defaults(input string tag);
        check({tag, " R10 clk_src"}, 32'(clk_src), 32'd0);
        check({tag, " R10 pll"}, {pll_ready, pll_mode, pll_mult, pll_div, pll_post}, 32'd0);
        check({tag, " R10 filters"}, 32'(flt_cfg), 32'd0);
        check({tag, " R10 strobes"}, {wp_on, seed_load, cmd_error, sys_reset_pulse}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            runs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("boot");

        // Table walk: R3, R6, R8 across a mixed sequence.
        for (int i = 0; i < 13; i++) begin
            send(VEC[i][35:4]);
            check($sformatf("R8 vec%0d err", i), 32'(cmd_error), 32'(VEC[i][3]));
            check($sformatf("R3 vec%0d clk_src", i), 32'(clk_src), 32'(VEC[i][2:1]));
            check($sformatf("R6 vec%0d wp_on", i), 32'(wp_on), 32'(VEC[i][0]));
        end

        // R8: error lasts one cycle.
        @(negedge clk);
        check("R8 error one cycle", 32'(cmd_error), 32'd0);

        // R2 / R4: full PLL field load, external clock-in mode.
        send(32'h009A9556);
        check("R2 mode", 32'(pll_mode), 32'd1);
        check("R2 mult", 32'(pll_mult), 32'h155);
        check("R2 div", 32'(pll_div), 32'h2A);
        check("R2 post", 32'(pll_post), 32'h9);
        check("R4 ext_clk_in", 32'(ext_clk_in), 32'd1);

        // R2: other commands leave PLL fields alone.
        send(32'h00000180);
        check("R2 hold mult", 32'(pll_mult), 32'h155);

        // R4: power-down tracks slow source.
        send(32'h00000060);
        check("R4 power_down", 32'(power_down), 32'd1);
        send(32'h00000020);
        check("R4 power_down off", 32'(power_down), 32'd0);

        // R5: filter 2 gets len 3 tap 0x15; others stay zero.
        send(32'h0000BAC0);
        check("R5 filter2", 32'(flt_cfg[20:14]), 32'h75);
        check("R5 others", 32'({flt_cfg[27:21], flt_cfg[13:0]}), 32'd0);

        // R1: seed payload and single-cycle strobe.
        send(32'hDEADBEEF);
        check("R1 strobe", 32'(seed_load), 32'd1);
        check("R1 value", 32'(seed_value), 32'h6F56DF77);
        @(negedge clk);
        check("R1 strobe width", 32'(seed_load), 32'd0);

        // R9: protection gate (wp_on is 1 here).
        ram_wr_req  = 1'b1;
        ram_wr_addr = AW'(RAM_BYTES - 1);
        #1;
        check("R9 top denied", {ram_wr_grant, wp_violation}, 32'b01);
        ram_wr_addr = AW'(RAM_BYTES - PROT_BYTES);
        #1;
        check("R9 base denied", {ram_wr_grant, wp_violation}, 32'b01);
        ram_wr_addr = AW'(RAM_BYTES - PROT_BYTES - 1);
        #1;
        check("R9 below allowed", {ram_wr_grant, wp_violation}, 32'b10);
        send(32'h00000080);
        ram_wr_addr = AW'(RAM_BYTES - 1);
        #1;
        check("R9 unprotected", {ram_wr_grant, wp_violation}, 32'b10);
        ram_wr_req = 1'b0;
        #1;
        check("R9 no request", {ram_wr_grant, wp_violation}, 32'b00);

        // R7: reset pulse length.
        send(32'h00000100);
        cnt = 0;
        for (int i = 0; i < RST_CYCLES + 3; i++) begin
            if (sys_reset_pulse) cnt++;
            @(negedge clk);
        end
        check("R7 pulse length", 32'(cnt), 32'(RST_CYCLES));

        // R10: reset mid-run restores defaults.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("rerun");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule